// File: doc/BRIEF.md
# IOMMU QoS Identifier Tagging Unit

This block decides which resource-control ID and which monitoring ID go with each memory request that an IOMMU sends into the system. It holds a global QoS register, reached through a simple register read/write port. Writes to that register are legalized to the implemented ID width. The block also checks the two ID fields of a device-context translation-attributes word and flags a misconfigured context. Finally, it selects the IDs for each request class.

Accesses the IOMMU makes for its own queues, and device-directory walks made before a context is known, carry the IDs from the global register. Walks of structures linked from a device context carry the IDs stored in that context. These structures are the process directory, both page-table stages, the MSI page table and the memory-resident interrupt file. Device traffic after a successful translation also carries the context IDs, so the bridge can tag the device's own request.

A build-time switch says whether QoS support exists. Without it, the register reads as zero and ignores writes. In that case any non-zero context ID field counts as a misconfiguration.

Top module: `iommu_qos_tagger`

## Requirements
- R1: Reading byte offset 4 (upper half of the 64-bit capabilities word) returns bit 9 (capability bit 41) equal to the QoS support switch, with every other bit 0. Any offset other than 4 and 624 reads 0.
- R2: The QoS register sits at byte offset 624. It holds the control ID in bits 11:0 and the monitoring ID in bits 27:16, and bits 15:12 and 31:28 read 0. A write is visible to reads from the next cycle.
- R3: On a write, bits of each ID field at or above ID_W are discarded before the value is stored.
- R4: After reset with the Bare reset translation mode, both register IDs read 0.
- R5: A context word is checked when dc_valid_i is high. The control ID is ta[51:40] and the monitoring ID is ta[63:52]. If either has a set bit at or above ID_W, dc_fault_o is high one cycle later; otherwise it is low.
- R6: While dc_fault_o is high, dc_cause_o is 259; otherwise it is 0.
- R7: A request of class 0 (own access) yields, one cycle later, tag_valid_o high with the register IDs as they stood before any write in the same cycle.
- R8: A request of class 1 (context-linked walk) yields, one cycle later, the context IDs. tag_valid_o is high only if that context word is legal.
- R9: A request of class 2 (device traffic) yields the context IDs one cycle later. tag_valid_o is high only if xlate_ok_i was high and the context word is legal.
- R10: Class 3, or req_valid_i low, yields tag_valid_o low. Whenever tag_valid_o is low, both tag ID outputs are 0.
- R11: Writes to any offset other than 624 leave the QoS register unchanged.
- R12: Without QoS support, offsets 4 and 624 read 0 and writes are dropped. A context word with any non-zero ID field raises dc_fault_o with cause 259.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| dc_valid_i | input | 1 | Context word present for checking |
| dc_ta_i | input | 64 | Device-context translation-attributes word |
| dc_fault_o | output | 1 | Context misconfigured |
| dc_cause_o | output | 12 | Fault cause code |
| req_valid_i | input | 1 | Request to be tagged |
| req_cls_i | input | 2 | Request class (0 own, 1 walk, 2 device, 3 none) |
| xlate_ok_i | input | 1 | Translation succeeded (device class) |
| tag_valid_o | output | 1 | Tag outputs valid |
| tag_rcid_o | output | 12 | Resource-control ID for the request |
| tag_mcid_o | output | 12 | Monitoring ID for the request |

## Verification
Register reads are combinational on the address, so a read is due in the same cycle the address is applied. A write shows up from the cycle after its clock edge. Context faults and tags both come from a single register stage, so each is due one cycle after the inputs that caused it. The bench model updates on the same edge the design does. It compares all outputs 2 ns after every rising edge, which is after that edge's update and before the inputs change on the falling edge.

// File: rtl/iommu_qos_pkg.sv
package iommu_qos_pkg;
  localparam int unsigned FIELD_W     = 12;
  localparam int unsigned CAUSE_W     = 12;
  localparam int unsigned QOS_REG_OFS = 624;
  localparam int unsigned CAP_HI_OFS  = 4;
  localparam int unsigned CAP_QOS_BIT = 41;
  localparam int unsigned CAUSE_DC_BAD = 259;
  localparam int unsigned TA_RCID_LSB = 40;
  localparam int unsigned TA_MCID_LSB = 52;

  typedef enum logic [1:0] {
    CLS_OWN  = 2'd0,
    CLS_WALK = 2'd1,
    CLS_DEV  = 2'd2,
    CLS_NONE = 2'd3
  } req_cls_e;

  typedef struct packed {
    logic [FIELD_W-1:0] mcid;
    logic [FIELD_W-1:0] rcid;
  } qos_ids_t;

  function automatic qos_ids_t ta_ids(input logic [63:0] ta);
    qos_ids_t r;
    r.rcid = ta[TA_RCID_LSB +: FIELD_W];
    r.mcid = ta[TA_MCID_LSB +: FIELD_W];
    return r;
  endfunction
endpackage

// File: rtl/qos_csr.sv
module qos_csr
  import iommu_qos_pkg::*;
#(
  parameter int unsigned ID_W       = 8,
  parameter bit          QOS_EN     = 1'b1,
  parameter bit          RESET_BARE = 1'b1,
  parameter int unsigned NB_RCID    = 1,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output qos_ids_t          ids_o
);
  localparam logic [FIELD_W-1:0] MASK     = FIELD_W'((1 << ID_W) - 1);
  localparam logic [FIELD_W-1:0] RST_RCID = RESET_BARE ? '0 : (FIELD_W'(NB_RCID) & MASK);
  localparam int unsigned        CAP_POS  = CAP_QOS_BIT - 32;

  logic hit_qos, hit_cap;
  assign hit_qos = (reg_addr_i == ADDR_W'(QOS_REG_OFS));
  assign hit_cap = (reg_addr_i == ADDR_W'(CAP_HI_OFS));

  generate
    if (QOS_EN) begin : g_qos
      logic [FIELD_W-1:0] rcid_q, mcid_q;
      logic unused_wd;
      assign unused_wd = ^{reg_wdata_i[31:28], reg_wdata_i[15:12]};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rcid_q <= RST_RCID;
          mcid_q <= '0;
        end else if (reg_we_i && hit_qos) begin
          rcid_q <= reg_wdata_i[11:0] & MASK;
          mcid_q <= reg_wdata_i[27:16] & MASK;
        end
      end

      assign ids_o.rcid = rcid_q;
      assign ids_o.mcid = mcid_q;

      always_comb begin
        reg_rdata_o = '0;
        if (hit_qos)      reg_rdata_o = {4'b0, mcid_q, 4'b0, rcid_q};
        else if (hit_cap) reg_rdata_o[CAP_POS] = 1'b1;
      end

      a_r3_warl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && hit_qos) |=>
          (rcid_q == ($past(reg_wdata_i[11:0]) & MASK)) &&
          (mcid_q == ($past(reg_wdata_i[27:16]) & MASK)));

      a_r11_no_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && !hit_qos) |=> ($stable(rcid_q) && $stable(mcid_q)));
    end else begin : g_noqos
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, reg_we_i, reg_wdata_i, hit_qos, hit_cap};
      assign ids_o       = '0;
      assign reg_rdata_o = '0;
    end
  endgenerate
endmodule

// File: rtl/qos_ctx_check.sv
module qos_ctx_check
  import iommu_qos_pkg::*;
#(
  parameter int unsigned ID_W   = 8,
  parameter bit          QOS_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dc_valid_i,
  input  logic [63:0]        dc_ta_i,
  output qos_ids_t           ids_o,
  output logic               legal_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [FIELD_W-1:0] MASK = QOS_EN ? FIELD_W'((1 << ID_W) - 1) : '0;

  qos_ids_t ids;
  logic     unused_ta;
  assign ids       = ta_ids(dc_ta_i);
  assign unused_ta = ^dc_ta_i[TA_RCID_LSB-1:0];

  // out-of-width bits (all bits when QoS is absent) make the context illegal
  assign legal_o = ((ids.rcid & ~MASK) == '0) && ((ids.mcid & ~MASK) == '0);
  assign ids_o   = ids;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      cause_o <= '0;
    end else begin
      fault_o <= dc_valid_i && !legal_o;
      cause_o <= (dc_valid_i && !legal_o) ? CAUSE_W'(CAUSE_DC_BAD) : '0;
    end
  end

  a_r5_fault_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(dc_valid_i));

  a_r6_cause_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o == CAUSE_W'(CAUSE_DC_BAD)));
endmodule

// File: rtl/qos_tag_sel.sv
module qos_tag_sel
  import iommu_qos_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_cls_i,
  input  logic               xlate_ok_i,
  input  qos_ids_t           reg_ids_i,
  input  qos_ids_t           ctx_ids_i,
  input  logic               ctx_legal_i,
  output logic               tag_valid_o,
  output logic [FIELD_W-1:0] tag_rcid_o,
  output logic [FIELD_W-1:0] tag_mcid_o
);
  req_cls_e cls;
  logic     sel_v;
  qos_ids_t sel_ids;

  assign cls = req_cls_e'(req_cls_i);

  always_comb begin
    sel_v   = 1'b0;
    sel_ids = '0;
    unique case (cls)
      CLS_OWN: begin
        sel_v   = 1'b1;
        sel_ids = reg_ids_i;
      end
      CLS_WALK: begin
        sel_v   = ctx_legal_i;
        sel_ids = ctx_ids_i;
      end
      CLS_DEV: begin
        sel_v   = ctx_legal_i && xlate_ok_i;
        sel_ids = ctx_ids_i;
      end
      default: ;
    endcase
    sel_v = sel_v && req_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_valid_o <= 1'b0;
      tag_rcid_o  <= '0;
      tag_mcid_o  <= '0;
    end else begin
      tag_valid_o <= sel_v;
      tag_rcid_o  <= sel_v ? sel_ids.rcid : '0;
      tag_mcid_o  <= sel_v ? sel_ids.mcid : '0;
    end
  end

  a_r9_dev_needs_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_valid_o && $past(req_cls_i) == CLS_DEV) |-> $past(xlate_ok_i));

  a_r8_walk_ids: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_valid_o && $past(req_cls_i) == CLS_WALK) |->
      (tag_rcid_o == $past(ctx_ids_i.rcid) && tag_mcid_o == $past(ctx_ids_i.mcid)));

  a_r7_own_ids: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_valid_o && $past(req_cls_i) == CLS_OWN) |->
      (tag_rcid_o == $past(reg_ids_i.rcid) && tag_mcid_o == $past(reg_ids_i.mcid)));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_valid_o |-> (tag_rcid_o == '0 && tag_mcid_o == '0));
endmodule

// File: rtl/iommu_qos_tagger.sv
module iommu_qos_tagger
  import iommu_qos_pkg::*;
#(
  parameter int unsigned ID_W       = 8,
  parameter bit          QOS_EN     = 1'b1,
  parameter bit          RESET_BARE = 1'b1,
  parameter int unsigned NB_RCID    = 1,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               dc_valid_i,
  input  logic [63:0]        dc_ta_i,
  output logic               dc_fault_o,
  output logic [CAUSE_W-1:0] dc_cause_o,
  input  logic               req_valid_i,
  input  logic [1:0]         req_cls_i,
  input  logic               xlate_ok_i,
  output logic               tag_valid_o,
  output logic [FIELD_W-1:0] tag_rcid_o,
  output logic [FIELD_W-1:0] tag_mcid_o
);
  qos_ids_t reg_ids, ctx_ids;
  logic     ctx_legal;

  qos_csr #(
    .ID_W(ID_W), .QOS_EN(QOS_EN), .RESET_BARE(RESET_BARE),
    .NB_RCID(NB_RCID), .ADDR_W(ADDR_W)
  ) u_csr (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ids_o(reg_ids)
  );

  qos_ctx_check #(.ID_W(ID_W), .QOS_EN(QOS_EN)) u_chk (
    .clk_i, .rst_ni, .dc_valid_i, .dc_ta_i,
    .ids_o(ctx_ids), .legal_o(ctx_legal), .fault_o(dc_fault_o), .cause_o(dc_cause_o)
  );

  qos_tag_sel u_sel (
    .clk_i, .rst_ni, .req_valid_i, .req_cls_i, .xlate_ok_i,
    .reg_ids_i(reg_ids), .ctx_ids_i(ctx_ids), .ctx_legal_i(ctx_legal),
    .tag_valid_o, .tag_rcid_o, .tag_mcid_o
  );
endmodule

// File: tb/iommu_qos_tagger_test.sv
module iommu_qos_tagger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic        dv = 1'b0;
  logic [63:0] ta = '0;
  logic        rv = 1'b0;
  logic [1:0]  cls = 2'd3;
  logic        ok = 1'b0;

  logic [31:0] rdata, rdata_nc;
  logic        fault, fault_nc, tv, tv_nc;
  logic [11:0] cause, cause_nc, trc, tmc, trc_nc, tmc_nc;

  int    n_tests = 0;
  int    n_fail  = 0;
  string focus   = "R4";

  always #4 clk = ~clk;

  iommu_qos_tagger #(.ID_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .dc_valid_i(dv), .dc_ta_i(ta), .dc_fault_o(fault),
    .dc_cause_o(cause), .req_valid_i(rv), .req_cls_i(cls), .xlate_ok_i(ok),
    .tag_valid_o(tv), .tag_rcid_o(trc), .tag_mcid_o(tmc));

  iommu_qos_tagger #(.ID_W(8), .QOS_EN(1'b0)) uut_nc (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata_nc), .dc_valid_i(dv), .dc_ta_i(ta), .dc_fault_o(fault_nc),
    .dc_cause_o(cause_nc), .req_valid_i(rv), .req_cls_i(cls), .xlate_ok_i(ok),
    .tag_valid_o(tv_nc), .tag_rcid_o(trc_nc), .tag_mcid_o(tmc_nc));

  // behavioural reference model
  int m_rc = 0, m_mc = 0;
  int e_tv = 0, e_rc = 0, e_mc = 0, e_f = 0, e_nf = 0;

  function automatic bit ctx_ok(logic [63:0] t);
    return (t[51:48] == 0) && (t[63:60] == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rc <= 0; m_mc <= 0; e_tv <= 0; e_rc <= 0; e_mc <= 0; e_f <= 0; e_nf <= 0;
    end else begin
      int v, r, m;
      v = 0; r = 0; m = 0;
      if (we && addr == 624) begin
        m_rc <= wd[11:0] & 12'hFF;
        m_mc <= wd[27:16] & 12'hFF;
      end
      e_f  <= dv && !ctx_ok(ta);
      e_nf <= dv && (ta[63:40] != 0);
      if (rv) begin
        if (cls == 0) begin v = 1; r = m_rc; m = m_mc; end
        else if (cls == 1) begin v = ctx_ok(ta); r = ta[51:40]; m = ta[63:52]; end
        else if (cls == 2) begin v = ctx_ok(ta) && ok; r = ta[51:40]; m = ta[63:52]; end
      end
      e_tv <= v;
      e_rc <= v ? r : 0;
      e_mc <= v ? m : 0;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", focus, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [31:0] er;
      er = 0;
      if (addr == 4) er = 32'h200;
      else if (addr == 624) er = {4'b0, m_mc[11:0], 4'b0, m_rc[11:0]};
      chk("rdata R2", rdata, er);
      chk("fault R5", {31'b0, fault}, e_f);
      chk("cause R6", {20'b0, cause}, e_f ? 259 : 0);
      chk("tag R7/8/9/10", {7'b0, tv, trc, tmc}, {7'b0, e_tv[0], e_rc[11:0], e_mc[11:0]});
      chk("nocap rdata R12", rdata_nc, 0);
      chk("nocap fault R12", {19'b0, fault_nc, cause_nc}, {19'b0, e_nf[0], e_nf ? 12'd259 : 12'd0});
    end
  end

  task automatic cyc(logic w, logic [11:0] a, logic [31:0] d, logic v,
                     logic [63:0] t, logic r, logic [1:0] c, logic o);
    @(negedge clk);
    we = w; addr = a; wd = d; dv = v; ta = t; rv = r; cls = c; ok = o;
  endtask

  function automatic logic [63:0] mk(logic [11:0] rc, logic [11:0] mc, logic [39:0] lo);
    return {mc, rc, lo};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    focus = "R4";  cyc(0, 624, 0, 0, 0, 0, 3, 0);
    focus = "R1";  cyc(0, 4, 0, 0, 0, 0, 3, 0); cyc(0, 0, 0, 0, 0, 0, 3, 0);
                   cyc(0, 8, 0, 0, 0, 0, 3, 0);
    focus = "R2";  cyc(1, 624, 32'h00BC_0023, 0, 0, 0, 3, 0); cyc(0, 624, 0, 0, 0, 0, 3, 0);
    focus = "R3";  cyc(1, 624, 32'hFFFF_FFFF, 0, 0, 0, 3, 0); cyc(0, 624, 0, 0, 0, 0, 3, 0);
                   cyc(1, 624, 32'h0F00_0F00, 0, 0, 0, 3, 0); cyc(0, 624, 0, 0, 0, 0, 3, 0);
                   cyc(1, 624, 32'h0055_0077, 0, 0, 0, 3, 0);
    focus = "R11"; cyc(1, 628, 32'hFFFF_FFFF, 0, 0, 0, 3, 0); cyc(1, 0, 32'h1234, 0, 0, 0, 3, 0);
                   cyc(0, 624, 0, 0, 0, 0, 3, 0);
    focus = "R7";  cyc(0, 624, 0, 0, 0, 1, 0, 0);
                   cyc(1, 624, 32'h0011_0022, 0, 0, 1, 0, 0); cyc(0, 624, 0, 0, 0, 1, 0, 0);
    focus = "R5";  cyc(0, 0, 0, 1, mk(12'h012, 12'h034, 40'hFF_FFFF_FFFF), 0, 3, 0);
                   cyc(0, 0, 0, 1, mk(12'h100, 12'h034, 0), 0, 3, 0);
                   cyc(0, 0, 0, 1, mk(12'h012, 12'h800, 0), 0, 3, 0);
    focus = "R6";  cyc(0, 0, 0, 1, mk(12'hFFF, 12'hFFF, 0), 0, 3, 0);
                   cyc(0, 0, 0, 1, mk(12'h0FF, 12'h0FF, 0), 0, 3, 0);
    focus = "R8";  cyc(0, 0, 0, 1, mk(12'h0A5, 12'h05A, 40'h12345), 1, 1, 0);
                   cyc(0, 0, 0, 1, mk(12'h2A5, 12'h05A, 0), 1, 1, 0);
    focus = "R9";  cyc(0, 0, 0, 1, mk(12'h0C3, 12'h03C, 0), 1, 2, 1);
                   cyc(0, 0, 0, 1, mk(12'h0C3, 12'h03C, 0), 1, 2, 0);
                   cyc(0, 0, 0, 1, mk(12'h0C3, 12'h43C, 0), 1, 2, 1);
    focus = "R10"; cyc(0, 0, 0, 1, mk(12'h011, 12'h022, 0), 1, 3, 1);
                   cyc(0, 0, 0, 1, mk(12'h011, 12'h022, 0), 0, 0, 1);
                   cyc(0, 0, 0, 0, 0, 0, 2, 1);
    focus = "R12"; cyc(0, 0, 0, 1, mk(12'h001, 12'h000, 0), 0, 3, 0);
                   cyc(0, 4, 0, 0, 0, 0, 3, 0);
    focus = "RND";
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      logic [63:0] t;
      int s;
      s = $urandom_range(0, 3);
      a = (s == 0) ? 12'd0 : (s == 1) ? 12'd4 : (s == 2) ? 12'd624 : 12'd628;
      t = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) t[63:40] = t[63:40] & 24'h0FF0FF;
      cyc(1'($urandom_range(0, 1)), a, $urandom, 1'($urandom_range(0, 1)), t,
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    cyc(0, 624, 0, 0, 0, 0, 3, 0);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule